// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the decision core of an eight-input interrupt controller. It keeps a pending-request register, a mask register and an in-service register. It latches each request line as level- or edge-sensitive, as a per-line mode input selects. It ranks pending lines in a rotating order that starts at a programmable base line, and it raises an interrupt output toward the processor whenever the best unmasked request outranks everything already in service.

When the processor acknowledges, the block moves the winning line into service and reports its number on the vector output. It also carries out non-specific end-of-interrupt clears, which can optionally rotate, and automatic end-of-interrupt at acknowledge time. The trigger modes, mask, rotation base, nested-cascade mode and automatic end-of-interrupt settings all arrive as plain inputs. Register programming, bus decoding and cascading of several controllers sit outside.

Top module: `rot_irq_resolver`

## Requirements
- R1: After reset the pending, in-service and mask registers are all zero, the rotation base is 0, `irq_o` is low and `vector_o` is 7.
- R2: Line i has rank (i - base) mod 8, and rank 0 is the strongest. `vector_o` gives the pending unmasked line with the lowest rank while `irq_o` is high, and 7 otherwise.
- R3: `irq_o` is high exactly when some unmasked line is pending and its best rank is strictly lower than the best rank in service. An empty in-service set counts as rank 8.
- R4: Where `level_mode_i` bit i is 1, pending bit i takes the value of `req_i[i]` at each clock edge. Where it is 0, pending bit i is set only when `req_i[i]` is 1 and was 0 at the previous edge. A new rising edge in the same cycle as the acknowledge of that line leaves the bit set.
- R5: An acknowledge (`ack_i`) while `irq_o` is high sets the in-service bit of the winner at the next edge. It clears the winner's pending bit only if that line is edge-triggered. An acknowledge while `irq_o` is low leaves the in-service register unchanged.
- R6: With `auto_eoi_i` set, an acknowledge leaves the winner's in-service bit clear. If `auto_eoi_rotate_i` is also set, the base becomes (winner + 1) mod 8.
- R7: With `nest_cascade_i` set, in-service bit 2 is ignored when the R3 comparison takes the in-service rank.
- R8: `eoi_i` without `ack_i` clears the in-service bit of lowest rank, taken over the whole in-service register. With `eoi_rotate_i`, the base becomes (that line + 1) mod 8. With nothing in service it changes nothing. When `ack_i` is also high, `eoi_i` is ignored.
- R9: `mask_i` is registered at each edge. A masked line is still latched as pending but takes no part in R2 and R3.
- R10: `base_load_i` loads `base_val_i` into the base at the next edge, unless an R6 or R8 rotation happens in the same cycle; the rotation then wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 8 | Raw interrupt request lines |
| level_mode_i | input | 8 | Per-line trigger mode, 1 = level, 0 = edge |
| mask_i | input | 8 | Per-line mask, 1 = masked |
| base_load_i | input | 1 | Load the rotation base |
| base_val_i | input | 3 | New rotation base |
| nest_cascade_i | input | 1 | Ignore the cascade line's in-service bit for preemption |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt on acknowledge |
| auto_eoi_rotate_i | input | 1 | Rotate the base on automatic end-of-interrupt |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| eoi_i | input | 1 | Non-specific end-of-interrupt strobe |
| eoi_rotate_i | input | 1 | Rotate the base on end-of-interrupt |
| irq_o | output | 1 | Interrupt request to the processor |
| vector_o | output | 3 | Winning line, 7 when none |
| irr_o | output | 8 | Pending-request register |
| isr_o | output | 8 | In-service register |
| base_o | output | 3 | Current rotation base |

## Verification
A stuck or wrong pending bit shows on `irr_o` at the next edge after the request changes. It also shows on `irq_o` and `vector_o` in the same cycle, because resolution is combinational. A wrong in-service update or wrong rotation base shows up on `isr_o` or `base_o` one edge after the acknowledge or end-of-interrupt. Within that same cycle it also changes who may preempt, so `irq_o` and `vector_o` shift too. The bench compares all five outputs every cycle against a reference model, so any such divergence is reported within one clock.

// File: rtl/rir_pkg.sv
package rir_pkg;
    localparam int unsigned RIR_LINES = 8;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;
endpackage

// File: rtl/rir_rank_scan.sv
module rir_rank_scan #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0]           vec_i,
    input  logic [$clog2(N)-1:0]   base_i,
    output logic                   hit_o,
    output logic [$clog2(N):0]     rank_o
);
    localparam int unsigned W = $clog2(N);

    logic [N-1:0] rot_w;

    always_comb begin
        for (int k = 0; k < N; k++) begin
            rot_w[k] = vec_i[W'(base_i + W'(k))];
        end
        rank_o = (W+1)'(N);
        for (int k = N - 1; k >= 0; k--) begin
            if (rot_w[k]) begin
                rank_o = (W+1)'(k);
            end
        end
        hit_o = |vec_i;
    end
endmodule

// File: rtl/rir_line_latch.sv
module rir_line_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic level_i,
    input  logic ack_clr_i,
    output logic pend_o
);
    import rir_pkg::*;

    typedef struct packed {
        logic pend;
        logic last;
    } line_t;

    line_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.last = req_i;
        if (trig_mode_e'(level_i) == TRIG_LEVEL) begin
            st_d.pend = req_i;
        end else begin
            st_d.pend = (st_q.pend & ~ack_clr_i) | (req_i & ~st_q.last);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    // R4: a level line mirrors the input sampled at the previous edge
    assert_level_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        level_i |=> (pend_o == $past(req_i)));

    // R4: an edge line cannot become pending without a rising edge
    assert_edge_needs_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_i && !pend_o && !(req_i && !st_q.last)) |=> !pend_o);
endmodule

// File: rtl/rot_irq_resolver.sv
module rot_irq_resolver #(
    parameter int unsigned N            = rir_pkg::RIR_LINES,
    parameter int unsigned CASCADE_LINE = 2,
    parameter bit          IS_MASTER    = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          req_i,
    input  logic [N-1:0]          level_mode_i,
    input  logic [N-1:0]          mask_i,
    input  logic                  base_load_i,
    input  logic [$clog2(N)-1:0]  base_val_i,
    input  logic                  nest_cascade_i,
    input  logic                  auto_eoi_i,
    input  logic                  auto_eoi_rotate_i,
    input  logic                  ack_i,
    input  logic                  eoi_i,
    input  logic                  eoi_rotate_i,
    output logic                  irq_o,
    output logic [$clog2(N)-1:0]  vector_o,
    output logic [N-1:0]          irr_o,
    output logic [N-1:0]          isr_o,
    output logic [$clog2(N)-1:0]  base_o
);
    localparam int unsigned W = $clog2(N);

    typedef struct packed {
        logic [N-1:0] isr;
        logic [N-1:0] mask;
        logic [W-1:0] base;
    } core_t;

    core_t st_d, st_q;

    logic [N-1:0] irr_w;
    logic [N-1:0] pend_w;
    logic [N-1:0] svc_vis_w;
    logic         pend_hit, svc_hit, eoi_hit;
    logic [W:0]   pend_rank, svc_rank, eoi_rank;
    logic [W-1:0] pend_line, eoi_line;
    logic         grant_w;
    logic         take_w;

    always_comb begin
        pend_w    = irr_w & ~st_q.mask;
        svc_vis_w = st_q.isr;
        if (IS_MASTER && nest_cascade_i && (CASCADE_LINE < N)) begin
            svc_vis_w[CASCADE_LINE] = 1'b0;
        end
    end

    rir_rank_scan #(.N(N)) u_pend_scan (
        .vec_i  (pend_w),
        .base_i (st_q.base),
        .hit_o  (pend_hit),
        .rank_o (pend_rank)
    );

    rir_rank_scan #(.N(N)) u_svc_scan (
        .vec_i  (svc_vis_w),
        .base_i (st_q.base),
        .hit_o  (svc_hit),
        .rank_o (svc_rank)
    );

    rir_rank_scan #(.N(N)) u_eoi_scan (
        .vec_i  (st_q.isr),
        .base_i (st_q.base),
        .hit_o  (eoi_hit),
        .rank_o (eoi_rank)
    );

    always_comb begin
        pend_line = st_q.base + pend_rank[W-1:0];
        eoi_line  = st_q.base + eoi_rank[W-1:0];
        grant_w   = pend_hit && (!svc_hit || (pend_rank < svc_rank));
        take_w    = ack_i && grant_w;
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_line
            rir_line_latch u_latch (
                .clk       (clk),
                .rst_n     (rst_n),
                .req_i     (req_i[i]),
                .level_i   (level_mode_i[i]),
                .ack_clr_i (take_w && (pend_line == W'(i))),
                .pend_o    (irr_w[i])
            );
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.mask = mask_i;
        if (base_load_i) begin
            st_d.base = base_val_i;
        end
        if (take_w) begin
            if (auto_eoi_i) begin
                st_d.isr[pend_line] = 1'b0;
                if (auto_eoi_rotate_i) begin
                    st_d.base = pend_line + W'(1);
                end
            end else begin
                st_d.isr[pend_line] = 1'b1;
            end
        end else if (eoi_i && !ack_i && eoi_hit) begin
            st_d.isr[eoi_line] = 1'b0;
            if (eoi_rotate_i) begin
                st_d.base = eoi_line + W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o    = grant_w;
    assign vector_o = grant_w ? pend_line : W'(N - 1);
    assign irr_o    = irr_w;
    assign isr_o    = st_q.isr;
    assign base_o   = st_q.base;

    // R3: the request output needs at least one unmasked pending line
    assert_irq_has_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|(irr_o & ~st_q.mask)));

    // R5: a granted acknowledge puts the winner in service
    assert_ack_sets_isr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !auto_eoi_i) |=> isr_o[$past(vector_o)]);

    // R5: an acknowledge with no grant and no end-of-interrupt leaves service alone
    assert_ack_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_o) |=> $stable(isr_o));

    // R6: automatic end-of-interrupt leaves the winner out of service
    assert_aeoi_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && auto_eoi_i) |=> !isr_o[$past(vector_o)]);

    // R6: rotation on automatic end-of-interrupt moves the base past the winner
    assert_aeoi_rotate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && auto_eoi_i && auto_eoi_rotate_i)
            |=> (base_o == W'($past(vector_o) + W'(1))));

    // R8: an end-of-interrupt with nothing in service keeps it empty
    assert_eoi_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !ack_i && (isr_o == '0)) |=> (isr_o == '0));
endmodule

// File: tb/rot_irq_resolver_test.sv
`timescale 1ns/1ps
module rot_irq_resolver_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_i = '0, level_mode_i = '0, mask_i = '0;
    logic       base_load_i = 1'b0;
    logic [2:0] base_val_i = '0;
    logic       nest_cascade_i = 1'b0, auto_eoi_i = 1'b0, auto_eoi_rotate_i = 1'b0;
    logic       ack_i = 1'b0, eoi_i = 1'b0, eoi_rotate_i = 1'b0;
    logic       irq_o;
    logic [2:0] vector_o, base_o;
    logic [7:0] irr_o, isr_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    bit [7:0] m_irr, m_isr, m_mask, m_last;
    bit [2:0] m_base;

    always #4 clk = ~clk;

    rot_irq_resolver uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .level_mode_i(level_mode_i),
        .mask_i(mask_i), .base_load_i(base_load_i), .base_val_i(base_val_i),
        .nest_cascade_i(nest_cascade_i), .auto_eoi_i(auto_eoi_i),
        .auto_eoi_rotate_i(auto_eoi_rotate_i), .ack_i(ack_i), .eoi_i(eoi_i),
        .eoi_rotate_i(eoi_rotate_i), .irq_o(irq_o), .vector_o(vector_o),
        .irr_o(irr_o), .isr_o(isr_o), .base_o(base_o)
    );

    function automatic int rank_of(bit [7:0] v, bit [2:0] b);
        for (int k = 0; k < 8; k++) begin
            bit [2:0] idx = b + 3'(k);
            if (v[idx]) return k;
        end
        return 8;
    endfunction

    function automatic bit exp_irq();
        bit [7:0] sv = m_isr;
        if (nest_cascade_i) sv[2] = 1'b0;
        return rank_of(m_irr & ~m_mask, m_base) < rank_of(sv, m_base);
    endfunction

    function automatic bit [2:0] exp_vec();
        if (!exp_irq()) return 3'd7;
        return m_base + 3'(rank_of(m_irr & ~m_mask, m_base));
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R4 pending register", int'(irr_o), int'(m_irr));
        check("R5 in-service register", int'(isr_o), int'(m_isr));
        check("R6 rotation base", int'(base_o), int'(m_base));
        check("R3 request output", int'(irq_o), int'(exp_irq()));
        check("R2 winning vector", int'(vector_o), int'(exp_vec()));
    endtask

    task automatic tick();
        bit       g = exp_irq();
        bit [2:0] w = exp_vec();
        bit [7:0] n_irr, n_isr;
        bit [2:0] n_base = m_base;
        int       ke;
        for (int i = 0; i < 8; i++) begin
            if (level_mode_i[i]) n_irr[i] = req_i[i];
            else n_irr[i] = (m_irr[i] & ~(ack_i && g && (w == 3'(i)))) | (req_i[i] & ~m_last[i]);
        end
        n_isr = m_isr;
        if (base_load_i) n_base = base_val_i;
        if (ack_i && g) begin
            if (auto_eoi_i) begin
                n_isr[w] = 1'b0;
                if (auto_eoi_rotate_i) n_base = w + 3'd1;
            end else begin
                n_isr[w] = 1'b1;
            end
        end else if (eoi_i && !ack_i) begin
            ke = rank_of(m_isr, m_base);
            if (ke < 8) begin
                bit [2:0] ln = m_base + 3'(ke);
                n_isr[ln] = 1'b0;
                if (eoi_rotate_i) n_base = ln + 3'd1;
            end
        end
        @(posedge clk);
        m_irr = n_irr; m_isr = n_isr; m_base = n_base;
        m_mask = mask_i; m_last = req_i;
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        req_i = '0; level_mode_i = '0; mask_i = '0; base_load_i = 0; base_val_i = '0;
        nest_cascade_i = 0; auto_eoi_i = 0; auto_eoi_rotate_i = 0;
        ack_i = 0; eoi_i = 0; eoi_rotate_i = 0;
        rst_n = 1'b0;
        m_irr = '0; m_isr = '0; m_mask = '0; m_last = '0; m_base = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset pending", int'(irr_o), 0);
        check("R1 reset in-service", int'(isr_o), 0);
        check("R1 reset base", int'(base_o), 0);
        check("R1 reset irq", int'(irq_o), 0);
        check("R1 reset vector", int'(vector_o), 7);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = int'($urandom(32'd51966));

        // R2 / R10: rotated winner
        do_reset();
        level_mode_i = 8'hFF; base_load_i = 1; base_val_i = 3'd5; req_i = 8'b0100_0010;
        tick();
        base_load_i = 0;
        check("R10 base loaded", int'(base_o), 5);
        check("R2 line 6 outranks line 1 at base 5", int'(vector_o), 6);
        ack_i = 1; tick(); ack_i = 0;
        check("R5 winner in service", int'(isr_o), 8'h40);
        check("R5 level line stays pending", int'(irr_o[6]), 1);
        check("R3 equal rank does not preempt", int'(irq_o), 0);
        eoi_i = 1; tick(); eoi_i = 0;
        check("R8 eoi clears top in-service", int'(isr_o), 0);
        check("R3 request returns after eoi", int'(irq_o), 1);
        req_i = '0; eoi_i = 1; tick(); eoi_i = 0;
        check("R8 eoi on empty changes nothing", int'(isr_o), 0);
        check("R8 eoi on empty keeps base", int'(base_o), 5);

        // R7: nested cascade mode
        do_reset();
        req_i = 8'h04; tick();
        req_i = 8'h00; ack_i = 1; tick(); ack_i = 0;
        check("R7 cascade line in service", int'(isr_o), 8'h04);
        req_i = 8'h04; tick();
        check("R7 blocked without nested mode", int'(irq_o), 0);
        nest_cascade_i = 1; tick();
        check("R7 preempts in nested mode", int'(irq_o), 1);
        check("R7 vector is cascade line", int'(vector_o), 2);
        nest_cascade_i = 0;

        // R9: mask
        do_reset();
        mask_i = 8'h08; req_i = 8'h08; tick();
        check("R9 masked line still latched", int'(irr_o), 8'h08);
        check("R9 masked line gives no request", int'(irq_o), 0);
        mask_i = 8'h00; tick();
        check("R9 unmasked line requests", int'(irq_o), 1);

        // R6: automatic end-of-interrupt with rotation
        do_reset();
        auto_eoi_i = 1; auto_eoi_rotate_i = 1; req_i = 8'h10; tick();
        ack_i = 1; tick(); ack_i = 0;
        check("R6 auto eoi leaves nothing in service", int'(isr_o), 0);
        check("R6 base moves past winner", int'(base_o), 5);
        check("R5 edge line cleared on ack while held high", int'(irr_o), 0);
        auto_eoi_i = 0; auto_eoi_rotate_i = 0;

        // R10: rotation beats load
        do_reset();
        level_mode_i = 8'hFF; req_i = 8'h01; tick();
        ack_i = 1; req_i = 8'h00; tick(); ack_i = 0;
        eoi_i = 1; eoi_rotate_i = 1; base_load_i = 1; base_val_i = 3'd3; tick();
        eoi_i = 0; eoi_rotate_i = 0; base_load_i = 0;
        check("R10 eoi rotation wins over load", int'(base_o), 1);
        check("R8 rotating eoi clears line 0", int'(isr_o), 0);

        // R4: new edge during acknowledge
        do_reset();
        req_i = 8'h01; tick();
        req_i = 8'h00; tick();
        req_i = 8'h01; ack_i = 1; tick(); ack_i = 0;
        check("R4 fresh edge survives ack", int'(irr_o[0]), 1);
        check("R5 acked line in service", int'(isr_o), 8'h01);

        // Random phase
        do_reset();
        for (int c = 0; c < 6000; c++) begin
            if (c % 1500 == 1499) do_reset();
            req_i        = req_i ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
            if ($urandom % 50 == 0) level_mode_i = 8'($urandom);
            if ($urandom % 30 == 0) mask_i = 8'($urandom) & 8'($urandom);
            base_load_i  = ($urandom % 20 == 0);
            base_val_i   = 3'($urandom);
            if ($urandom % 40 == 0) nest_cascade_i = ~nest_cascade_i;
            if ($urandom % 40 == 0) auto_eoi_i = ~auto_eoi_i;
            auto_eoi_rotate_i = 1'($urandom);
            ack_i        = ($urandom % 4 == 0);
            eoi_i        = ($urandom % 4 == 0);
            eoi_rotate_i = 1'($urandom);
            tick();
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule